// File: doc/BRIEF.md
# NOP Fetch Bus Pattern Generator

This block reproduces the address-bus and strobe activity of an 8-bit processor that comes out of reset and only ever reads the opcode zero. Because that opcode does nothing, every instruction is just a fetch followed by a refresh slot, and the bus pattern is fully predictable. The block can drive a signature analyser, a bus monitor or a decoder testbench with that known pattern without needing a real processor core.

Each instruction cycle has a fetch phase and a refresh phase. In the fetch phase the bus carries a 16-bit fetch address, and an active-low read strobe is asserted. In the refresh phase the bus carries three things at once. The low seven bits hold a refresh counter. Bit 7 is held at zero. The high byte holds an interrupt-vector register, and an active-low refresh strobe is asserted. The vector register clears on reset. A write port can load it, so that a non-zero high byte can be produced during refresh.

Top module: `nop_fetch_busgen`

## Requirements
- R1: In the first clock tick after a synchronous reset, the block shows a fetch phase with address 0x0000, rd_n=0, rfsh_n=1 and fetch_phase=1.
- R2: With the default parameters, a cycle lasts four ticks. The first two ticks are fetch (fetch_phase=1, rd_n=0, rfsh_n=1). The last two ticks are refresh (fetch_phase=0, rd_n=1, rfsh_n=0). rd_n and rfsh_n are never equal.
- R3: In the fetch phase, addr equals the fetch address. The fetch address is constant within a cycle and rises by one per cycle.
- R4: In the refresh phase, addr[6:0] carries a 7-bit refresh counter. The counter is 0 after reset, rises by one per cycle, and wraps from 127 to 0.
- R5: In the refresh phase, addr[7] is 0.
- R6: In the refresh phase, addr[15:8] equals the vector register, which is 0x00 after reset.
- R7: When vec_we=1 at a clock edge, the vector register takes vec_wdata from the next tick onwards. A write does not change the fetch address, the refresh counter or the phase timing.
- R8: A reset asserted at any tick clears the fetch address, the refresh counter and the vector register, and restarts at the first fetch tick. Reset takes priority over a simultaneous vector write.
- R9: The fetch address stays in [0x0000, 0x7FFF] (bit 15 low) for the first 32768 cycles. It stays in [0x8000, 0xFFFF] for the next 32768 cycles. It then wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per tick |
| rst | input | 1 | Synchronous active-high reset |
| vec_we | input | 1 | Load strobe for the vector register |
| vec_wdata | input | 8 | Value loaded into the vector register |
| addr | output | 16 | Address bus: fetch address or refresh/vector pattern |
| rd_n | output | 1 | Active-low read strobe, low during fetch |
| rfsh_n | output | 1 | Active-low refresh strobe, low during refresh |
| fetch_phase | output | 1 | 1 during fetch ticks, 0 during refresh ticks |

## Verification
The bench first runs long stretches with the vector register at zero. On this pattern the fetch address and the refresh counter advance together, and the run crosses the 7-bit refresh wrap, so the bench can tell a counter that wraps at 128 from one that carries into bit 7. Vector writes of 0xA5, 0x3C and 0xFF are then issued in both phases. These show that the high byte follows the register during refresh while the fetch address and timing stay unaffected. A reset in mid-fetch, with a write on the same edge, separates reset priority from write priority. A second instance with one tick per phase covers all 65,536 fetch addresses. It checks the bit-15 halves and the wrap back to zero.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
    typedef enum logic {
        PH_REFRESH = 1'b0,
        PH_FETCH   = 1'b1
    } nfb_phase_e;
endpackage

// File: rtl/nfb_phase_seq.sv
module nfb_phase_seq #(
    parameter int FETCH_TICKS = 2,
    parameter int RFSH_TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    output nfb_pkg::nfb_phase_e phase,
    output logic              cyc_end
);
    localparam int CYC = FETCH_TICKS + RFSH_TICKS;
    localparam int CW  = (CYC > 2) ? $clog2(CYC) : 1;

    typedef struct packed {
        logic [CW-1:0] tick;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst)
            s_d.tick = '0;
        else if (s_q.tick == CW'(CYC - 1))
            s_d.tick = '0;
        else
            s_d.tick = s_q.tick + 1'b1;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign phase   = (s_q.tick < CW'(FETCH_TICKS)) ? nfb_pkg::PH_FETCH : nfb_pkg::PH_REFRESH;
    assign cyc_end = (s_q.tick == CW'(CYC - 1));
endmodule

// File: rtl/nfb_counters.sv
module nfb_counters #(
    parameter int PC_W = 16,
    parameter int RC_W = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output logic [PC_W-1:0] pc,
    output logic [RC_W-1:0] rc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [RC_W-1:0] rc;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (rst) begin
            c_d.pc = '0;
            c_d.rc = '0;
        end else if (adv) begin
            c_d.pc = c_q.pc + 1'b1;
            c_d.rc = c_q.rc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign pc = c_q.pc;
    assign rc = c_q.rc;
endmodule

// File: rtl/nfb_vec_reg.sv
module nfb_vec_reg #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [VEC_W-1:0] wdata,
    output logic [VEC_W-1:0] vec
);
    logic [VEC_W-1:0] vec_d, vec_q;

    always_comb begin
        vec_d = vec_q;
        if (rst)
            vec_d = '0;
        else if (we)
            vec_d = wdata;
    end

    always_ff @(posedge clk) begin
        vec_q <= vec_d;
    end

    assign vec = vec_q;
endmodule

// File: rtl/nfb_addr_mux.sv
module nfb_addr_mux #(
    parameter int ADDR_W = 16,
    parameter int RC_W   = 7,
    parameter int VEC_W  = 8
) (
    input  nfb_pkg::nfb_phase_e phase,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [RC_W-1:0]     rc,
    input  logic [VEC_W-1:0]    vec,
    output logic [ADDR_W-1:0]   addr,
    output logic                rd_n,
    output logic                rfsh_n
);
    localparam int GAP_W = ADDR_W - RC_W - VEC_W;

    logic [ADDR_W-1:0] rf_addr;

    generate
        if (GAP_W > 0) begin : g_gap
            assign rf_addr = {vec, {GAP_W{1'b0}}, rc};
        end else begin : g_nogap
            assign rf_addr = {vec, rc};
        end
    endgenerate

    always_comb begin
        if (phase == nfb_pkg::PH_FETCH) begin
            addr   = pc;
            rd_n   = 1'b0;
            rfsh_n = 1'b1;
        end else begin
            addr   = rf_addr;
            rd_n   = 1'b1;
            rfsh_n = 1'b0;
        end
    end
endmodule

// File: rtl/nop_fetch_busgen.sv
module nop_fetch_busgen #(
    parameter int ADDR_W      = 16,
    parameter int RC_W        = 7,
    parameter int VEC_W       = 8,
    parameter int FETCH_TICKS = 2,
    parameter int RFSH_TICKS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vec_we,
    input  logic [VEC_W-1:0]  vec_wdata,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_n,
    output logic              rfsh_n,
    output logic              fetch_phase
);
    nfb_pkg::nfb_phase_e phase;
    logic                cyc_end;
    logic [ADDR_W-1:0]   pc_cur;
    logic [RC_W-1:0]     rc_cur;
    logic [VEC_W-1:0]    vec_cur;

    nfb_phase_seq #(.FETCH_TICKS(FETCH_TICKS), .RFSH_TICKS(RFSH_TICKS)) u_seq (
        .clk(clk), .rst(rst), .phase(phase), .cyc_end(cyc_end)
    );

    nfb_counters #(.PC_W(ADDR_W), .RC_W(RC_W)) u_cnt (
        .clk(clk), .rst(rst), .adv(cyc_end), .pc(pc_cur), .rc(rc_cur)
    );

    nfb_vec_reg #(.VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst(rst), .we(vec_we), .wdata(vec_wdata), .vec(vec_cur)
    );

    nfb_addr_mux #(.ADDR_W(ADDR_W), .RC_W(RC_W), .VEC_W(VEC_W)) u_mux (
        .phase(phase), .pc(pc_cur), .rc(rc_cur), .vec(vec_cur),
        .addr(addr), .rd_n(rd_n), .rfsh_n(rfsh_n)
    );

    assign fetch_phase = (phase == nfb_pkg::PH_FETCH);
endmodule

// File: rtl/nop_fetch_busgen_chk.sv
module nop_fetch_busgen_chk #(
    parameter int ADDR_W = 16,
    parameter int RC_W   = 7,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              vec_we,
    input logic [VEC_W-1:0]  vec_wdata,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_n,
    input logic              rfsh_n,
    input logic              fetch_phase,
    input logic              cyc_end,
    input logic [ADDR_W-1:0] pc_cur,
    input logic [RC_W-1:0]   rc_cur,
    input logic [VEC_W-1:0]  vec_cur
);
    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_n != rfsh_n);

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> pc_cur == ADDR_W'($past(pc_cur) + 1'b1));

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cyc_end && !$past(rst)) |=> $stable(pc_cur));

    // R4
    rc_step_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_end |=> rc_cur == RC_W'($past(rc_cur) + 1'b1));

    // R5
    rfsh_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_phase |-> addr[RC_W] == 1'b0);

    // R6
    rfsh_hi_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_phase |-> addr[ADDR_W-1 -: VEC_W] == vec_cur);

    // R7
    vec_load_chk: assert property (@(posedge clk) disable iff (rst)
        vec_we |=> vec_cur == $past(vec_wdata));

    // R8
    reset_chk: assert property (@(posedge clk)
        rst |=> (fetch_phase && pc_cur == '0 && rc_cur == '0 && vec_cur == '0));
endmodule

bind nop_fetch_busgen nop_fetch_busgen_chk #(.ADDR_W(ADDR_W), .RC_W(RC_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst(rst), .vec_we(vec_we), .vec_wdata(vec_wdata),
    .addr(addr), .rd_n(rd_n), .rfsh_n(rfsh_n), .fetch_phase(fetch_phase),
    .cyc_end(cyc_end), .pc_cur(pc_cur), .rc_cur(rc_cur), .vec_cur(vec_cur)
);

// File: tb/nop_fetch_busgen_bench.sv
module nop_fetch_busgen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vec_we = 1'b0;
    logic [7:0]  vec_wdata = 8'h00;
    logic [15:0] addr;
    logic        rd_n, rfsh_n, fetch_phase;

    logic        rst_f = 1'b1;
    logic [15:0] addr_f;
    logic        rd_n_f, rfsh_n_f, ph_f;

    int checks = 0;
    int fails  = 0;
    bit main_done = 0;
    bit fast_done = 0;
    bit reported  = 0;

    always #2.5 clk = ~clk;

    nop_fetch_busgen u_nop_fetch_busgen (
        .clk(clk), .rst(rst), .vec_we(vec_we), .vec_wdata(vec_wdata),
        .addr(addr), .rd_n(rd_n), .rfsh_n(rfsh_n), .fetch_phase(fetch_phase)
    );

    nop_fetch_busgen #(.FETCH_TICKS(1), .RFSH_TICKS(1)) u_nop_fetch_busgen_fast (
        .clk(clk), .rst(rst_f), .vec_we(1'b0), .vec_wdata(8'h00),
        .addr(addr_f), .rd_n(rd_n_f), .rfsh_n(rfsh_n_f), .fetch_phase(ph_f)
    );

    typedef struct {
        logic [15:0] a;
        logic        rd;
        logic        rf;
        logic        ph;
        string       ctx;
    } exp_t;

    exp_t sb[$];

    int          m_t = 0;
    logic [15:0] m_pc = 0;
    logic [6:0]  m_rc = 0;
    logic [7:0]  m_vec = 0;

    task automatic chk(input bit ok, input string req, input string ctx,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s): actual=0x%0h expected=0x%0h", req, ctx, act, exp);
        end
    endtask

    // Driver: one call per tick; pushes what the current tick must show
    task automatic tick(input string ctx, input bit do_rst, input bit do_we,
                        input logic [7:0] wd);
        exp_t e;
        @(posedge clk);
        #1;
        e.ph  = (m_t < 2);
        e.rd  = !e.ph;
        e.rf  = e.ph;
        e.a   = e.ph ? m_pc : {m_vec, 1'b0, m_rc};
        e.ctx = ctx;
        sb.push_back(e);
        rst       = do_rst;
        vec_we    = do_we;
        vec_wdata = wd;
        if (do_rst) begin
            m_t = 0; m_pc = 0; m_rc = 0; m_vec = 0;
        end else begin
            if (do_we) m_vec = wd;
            if (m_t == 3) begin
                m_pc = m_pc + 1;
                m_rc = m_rc + 1;
            end
            m_t = (m_t + 1) % 4;
        end
    endtask

    // Monitor: pops one expectation per tick and compares
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(rd_n == e.rd && rfsh_n == e.rf && fetch_phase == e.ph, "R2", e.ctx,
                    {rd_n, rfsh_n, fetch_phase}, {e.rd, e.rf, e.ph});
                if (e.ph) begin
                    chk(addr == e.a, "R3", e.ctx, addr, e.a);
                end else begin
                    chk(addr[6:0] == e.a[6:0], "R4", e.ctx, addr[6:0], e.a[6:0]);
                    chk(addr[7] == 1'b0, "R5", e.ctx, addr[7], 0);
                    chk(addr[15:8] == e.a[15:8], "R6", e.ctx, addr[15:8], e.a[15:8]);
                end
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Main sequence on the default instance
    initial begin
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        m_t = 0; m_pc = 0; m_rc = 0; m_vec = 0;
        tick("R1 reset state", 0, 0, 8'h00);
        for (int i = 0; i < 3; i++) tick("R2 first cycle", 0, 0, 8'h00);
        for (int i = 0; i < 140 * 4; i++) tick("R4 wrap run", 0, 0, 8'h00);
        tick("R7 write A5 in fetch", 0, 1, 8'hA5);
        for (int i = 0; i < 12; i++) tick("R7 after A5", 0, 0, 8'h00);
        while (m_t != 2) tick("R7 align", 0, 0, 8'h00);
        tick("R7 write 3C in refresh", 0, 1, 8'h3C);
        for (int i = 0; i < 10; i++) tick("R7 after 3C", 0, 0, 8'h00);
        while (m_t != 1) tick("R8 align", 0, 0, 8'h00);
        tick("R8 reset with write", 1, 1, 8'h77);
        for (int i = 0; i < 8; i++) tick("R8 after reset", 0, 0, 8'h00);
        tick("R7 write FF", 0, 1, 8'hFF);
        for (int i = 0; i < 12; i++) tick("R7 after FF", 0, 0, 8'h00);
        repeat (3) @(posedge clk);
        main_done = 1;
        wait (fast_done);
        report();
    end

    // Fast instance: one tick per phase, full address sweep
    initial begin
        int k;
        int bad;
        k = 0;
        bad = 0;
        rst_f = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_f = 1'b0;
        while (k <= 65536) begin
            @(negedge clk);
            if (ph_f) begin
                if (addr_f != k[15:0]) bad++;
                if (k == 0)     chk(addr_f == 16'h0000, "R9", "first fetch", addr_f, 16'h0000);
                if (k == 32767) chk(addr_f[15] == 1'b0, "R9", "last low half", addr_f, 16'h7FFF);
                if (k == 32768) chk(addr_f[15] == 1'b1, "R9", "first high half", addr_f, 16'h8000);
                if (k == 65535) chk(addr_f == 16'hFFFF, "R9", "top address", addr_f, 16'hFFFF);
                if (k == 65536) chk(addr_f == 16'h0000, "R9", "wrap to zero", addr_f, 16'h0000);
                k++;
            end
        end
        chk(bad == 0, "R3", "full sweep sequential", bad, 0);
        fast_done = 1;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished main=%0d fast=%0d",
                 main_done, fast_done);
        report();
    end
endmodule